// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

This block is a single down-counting timer channel. Software selects an operating mode with a mode write, then supplies a full-width initial count with a count write. One clock equals one count step. A gate input either enables counting or acts as a rising-edge trigger, depending on the mode. A single output line carries a waveform that also depends on the mode.

The six modes are:
- interrupt on terminal count
- gate-retriggerable one-shot
- rate generator
- square-wave generator
- software-triggered strobe
- gate-triggered strobe

Counting can run either in plain binary or in four-decade decimal. An initial count of zero stands for the largest count the channel can hold.

For read-back, a latch request copies the counting element onto a held output. A null-count flag marks the interval after a count has been written and before it has been loaded into the counting element. While that flag is set, the count is not yet valid for read-back.

Top module: `intv_timer_chan`

## Requirements
- R1: While reset is asserted, `tmr_out` is 0, `null_count` is 1 and `rd_count` is 0.
- R2: `mode_sel` is the mode number in binary (0 through 5). Codes 6 and 7 have their top bit ignored, so they behave exactly as modes 2 and 3.
- R3: A mode write or a count write sets `null_count` to 1. The flag returns to 0 on the clock that loads the written count into the counting element.
- R4: In mode 0, a mode write drives the output low. A count write loads on the next clock, and the output rises N clocks after that load. The output then stays high until a new count or mode is written; a count write drives it low again.
- R5: In modes 0, 2, 3 and 4, a clock with the gate low leaves the count unchanged. A pulse on `latch_req` copies the current count onto `rd_count`, where it is held until the next pulse.
- R6: In mode 1, the output is high after the mode write and stays high until a gate rising edge. The clock that samples the edge loads the count and drives the output low for N clocks. A gate edge during the pulse reloads and extends it. A count written earlier is used at the next trigger.
- R7: In mode 2 with the gate high, the output is low for exactly one clock in every N clocks. That clock is the one on which the count reaches 1; the next clock reloads the count.
- R8: In mode 3, the output starts high on load and toggles every half period. An even N gives N/2 clocks high and N/2 clocks low. An odd N gives (N+1)/2 clocks high and (N-1)/2 clocks low.
- R9: In mode 4, the output is high. It goes low for one clock when the count reaches 0, which is N clocks after the load, and this happens only once per written count.
- R10: In mode 5, nothing counts until a gate rising edge loads the count. The output then goes low for one clock N clocks later. A later gate edge starts the same cycle again.
- R11: With `mode_bcd` = 1, the count is four decimal digits, one per nibble with the least significant digit in bits 3:0. Each digit borrows from the next digit up when it passes from 0 to 9.
- R12: An initial count of 0 gives 65536 clocks in binary and 10000 clocks in decimal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | One-clock strobe that writes the mode |
| mode_sel | input | 3 | Mode number |
| mode_bcd | input | 1 | 1 selects decimal counting |
| count_wr | input | 1 | One-clock strobe that writes the initial count |
| count_data | input | 16 | Initial count |
| gate | input | 1 | Gate: a level enable or a rising-edge trigger, by mode |
| latch_req | input | 1 | Copies the current count to `rd_count` |
| tmr_out | output | 1 | Mode waveform |
| null_count | output | 1 | Count written but not yet loaded |
| rd_count | output | 16 | Latched count for read-back |

## Verification
Each mode is driven with a small count, and its output is compared clock by clock against the edge positions that the requirements give. In mode 3, an even count and an odd count separate the correct phase split from a symmetric one. In mode 0, the gate is dropped in the middle of a count and the count is latched; this shows whether the gate holds the count or the counting element slips. A decimal count of 12 differs from its binary reading of 18, and a count that crosses 10 to 09 shows the digit borrow. In the trigger modes, repeated gate edges, edges in the middle of a pulse and a count rewritten between triggers separate retriggering from free running. Zero counts in both number systems confirm the largest count.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TRIG,
        ST_RUN
    } st_e;

    localparam logic [2:0] M_TC      = 3'd0;
    localparam logic [2:0] M_ONESHOT = 3'd1;
    localparam logic [2:0] M_RATE    = 3'd2;
    localparam logic [2:0] M_SQUARE  = 3'd3;
    localparam logic [2:0] M_SWSTB   = 3'd4;
    localparam logic [2:0] M_HWSTB   = 3'd5;

    function automatic logic [2:0] fold_mode(input logic [2:0] code);
        return (code[2] && code[1]) ? {1'b0, code[1:0]} : code;
    endfunction

    function automatic logic is_trig_mode(input logic [2:0] m);
        return (m == M_ONESHOT) || (m == M_HWSTB);
    endfunction

endpackage

// File: rtl/intv_gate_edge.sv
module intv_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign gate_rise = gate && !prev_q;
endmodule

// File: rtl/intv_count_step.sv
module intv_count_step #(
    parameter int DIGITS = 4,
    localparam int CW = 4 * DIGITS
) (
    input  logic [CW-1:0] val,
    input  logic          bcd,
    input  logic [1:0]    step,
    output logic [CW-1:0] res
);
    logic [CW-1:0] bin_res;
    logic [CW-1:0] dec_res;
    logic [DIGITS:0] bor;

    assign bor[0]  = 1'b0;
    assign bin_res = val - CW'(step);

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [1:0] sub;
        logic [4:0] diff;
        if (i == 0) begin : g_lsd
            assign sub = step;
        end else begin : g_upper
            assign sub = {1'b0, bor[i]};
        end
        assign diff       = {1'b0, val[4*i +: 4]} - {3'b000, sub};
        assign bor[i+1]   = diff[4];
        assign dec_res[4*i +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
    end

    assign res = bcd ? dec_res : bin_res;
endmodule

// File: rtl/intv_readback.sv
module intv_readback #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_req,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] rd_count
);
    logic [CW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (latch_req) rd_d = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_count = rd_q;
endmodule

// File: rtl/intv_timer_chan.sv
module intv_timer_chan
    import intv_timer_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int CW = 4 * DIGITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [2:0]    mode_sel,
    input  logic          mode_bcd,
    input  logic          count_wr,
    input  logic [CW-1:0] count_data,
    input  logic          gate,
    input  logic          latch_req,
    output logic          tmr_out,
    output logic          null_count,
    output logic [CW-1:0] rd_count
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [2:0]    mode;
        logic          bcd;
        logic [CW-1:0] cr;
        logic [CW-1:0] cnt;
        logic          out;
        logic          nul;
        logic          done;
        st_e           st;
    } regs_t;

    regs_t d, q;

    logic          gate_rise;
    logic [CW-1:0] dec;
    logic [1:0]    step;
    logic          dec_zero, dec_one, restart;
    logic [CW-1:0] cr_even;
    logic [2:0]    new_mode;

    intv_gate_edge u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .gate_rise(gate_rise)
    );

    assign step = ((q.mode == M_SQUARE) && !q.cnt[0]) ? 2'd2 : 2'd1;

    intv_count_step #(.DIGITS(DIGITS)) u_step (
        .val (q.cnt),
        .bcd (q.bcd),
        .step(step),
        .res (dec)
    );

    intv_readback #(.CW(CW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_req(latch_req),
        .cnt      (q.cnt),
        .rd_count (rd_count)
    );

    assign dec_zero = (dec == '0);
    assign dec_one  = (dec == ONE);
    assign cr_even  = {q.cr[CW-1:1], 1'b0};
    assign new_mode = fold_mode(mode_sel);
    assign restart  = (q.st == ST_IDLE) || (q.st == ST_LOAD) ||
                      ((q.st == ST_RUN) && ((q.mode == M_TC) || (q.mode == M_SWSTB)));

    always_comb begin
        d = q;
        case (q.st)
            ST_LOAD: begin
                d.cnt  = q.cr;
                d.nul  = 1'b0;
                d.done = 1'b0;
                d.st   = ST_RUN;
                d.out  = (q.mode != M_TC);
            end
            ST_TRIG: begin
                if (gate_rise) begin
                    d.cnt  = q.cr;
                    d.nul  = 1'b0;
                    d.done = 1'b0;
                    d.st   = ST_RUN;
                    d.out  = (q.mode != M_ONESHOT);
                end
            end
            ST_RUN: begin
                case (q.mode)
                    M_TC: begin
                        if (gate) begin
                            d.cnt = dec;
                            if (dec_zero) d.out = 1'b1;
                        end
                    end
                    M_ONESHOT: begin
                        if (gate_rise) begin
                            d.cnt = q.cr;
                            d.nul = 1'b0;
                            d.out = 1'b0;
                        end else begin
                            d.cnt = dec;
                            if (dec_zero) d.out = 1'b1;
                        end
                    end
                    M_RATE: begin
                        if (gate_rise) begin
                            d.cnt = q.cr;
                            d.nul = 1'b0;
                            d.out = 1'b1;
                        end else if (!gate) begin
                            d.out = 1'b1;
                        end else if (q.cnt == ONE) begin
                            d.cnt = q.cr;
                            d.nul = 1'b0;
                            d.out = 1'b1;
                        end else begin
                            d.cnt = dec;
                            d.out = !dec_one;
                        end
                    end
                    M_SQUARE: begin
                        if (gate_rise) begin
                            d.cnt = q.cr;
                            d.nul = 1'b0;
                            d.out = 1'b1;
                        end else if (!gate) begin
                            d.out = 1'b1;
                        end else if (dec_zero) begin
                            d.out = !q.out;
                            d.cnt = q.out ? cr_even : q.cr;
                            d.nul = 1'b0;
                        end else begin
                            d.cnt = dec;
                        end
                    end
                    M_SWSTB: begin
                        d.out = 1'b1;
                        if (gate) begin
                            d.cnt = dec;
                            if (dec_zero && !q.done) begin
                                d.out  = 1'b0;
                                d.done = 1'b1;
                            end
                        end
                    end
                    M_HWSTB: begin
                        d.out = 1'b1;
                        if (gate_rise) begin
                            d.cnt  = q.cr;
                            d.nul  = 1'b0;
                            d.done = 1'b0;
                        end else begin
                            d.cnt = dec;
                            if (dec_zero && !q.done) begin
                                d.out  = 1'b0;
                                d.done = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase

        if (count_wr) begin
            d.cr  = count_data;
            d.nul = 1'b1;
            if (restart) begin
                d.st   = is_trig_mode(q.mode) ? ST_TRIG : ST_LOAD;
                d.out  = (q.mode != M_TC);
                d.done = 1'b0;
            end
        end

        if (mode_wr) begin
            d.mode = new_mode;
            d.bcd  = mode_bcd;
            d.st   = ST_IDLE;
            d.out  = (new_mode != M_TC);
            d.nul  = 1'b1;
            d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode <= M_TC;
            q.bcd  <= 1'b0;
            q.cr   <= '0;
            q.cnt  <= '0;
            q.out  <= 1'b0;
            q.nul  <= 1'b1;
            q.done <= 1'b0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tmr_out    = q.out;
    assign null_count = q.nul;

    // R3
    null_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD && !mode_wr && !count_wr) |=> !null_count);

    // R4
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_TC && tmr_out && !mode_wr && !count_wr) |=> tmr_out);

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !gate && !mode_wr && !count_wr &&
         (q.mode == M_TC || q.mode == M_RATE || q.mode == M_SQUARE || q.mode == M_SWSTB))
        |=> $stable(q.cnt));

    // R7
    rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_RATE && !tmr_out && !mode_wr) |=> tmr_out);

    // R9
    sw_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_SWSTB && !tmr_out && !mode_wr) |=> tmr_out);

    // R10
    hw_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_HWSTB && !tmr_out && !mode_wr) |=> tmr_out);

endmodule

// File: tb/intv_timer_chan_tb.sv
`timescale 1ns/1ps
module intv_timer_chan_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [2:0]    mode_sel = 3'd0;
    logic          mode_bcd = 1'b0;
    logic          count_wr = 1'b0;
    logic [CW-1:0] count_data = '0;
    logic          gate = 1'b0;
    logic          latch_req = 1'b0;
    logic          tmr_out;
    logic          null_count;
    logic [CW-1:0] rd_count;

    always #2.5 clk = ~clk;

    intv_timer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel),
        .mode_bcd(mode_bcd), .count_wr(count_wr), .count_data(count_data),
        .gate(gate), .latch_req(latch_req), .tmr_out(tmr_out),
        .null_count(null_count), .rd_count(rd_count)
    );

    typedef struct {
        int          at;
        int          kind;
        logic [15:0] val;
        string       req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    task automatic push(int at, int kind, logic [15:0] val, string req);
        item_t it;
        int i;
        it.at = at; it.kind = kind; it.val = val; it.req = req;
        i = 0;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, it);
    endtask

    task automatic expect_out(int from, int to, bit v, string req);
        for (int k = from; k <= to; k++) push(k, 0, {15'b0, v}, req);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            it = sb.pop_front();
            case (it.kind)
                0:       check(it.req, "tmr_out", {15'b0, tmr_out}, it.val);
                1:       check(it.req, "null_count", {15'b0, null_count}, it.val);
                default: check(it.req, "rd_count", rd_count, it.val);
            endcase
        end
    end

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr_mode(logic [2:0] m, logic b);
        mode_sel = m; mode_bcd = b; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wr_count(logic [15:0] v);
        count_data = v; count_wr = 1'b1;
        @(negedge clk);
        count_wr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w, e, f, g, h;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "tmr_out", {15'b0, tmr_out}, 16'h0);
        check("R1", "null_count", {15'b0, null_count}, 16'h1);
        check("R1", "rd_count", rd_count, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 mode 0, N=5
        gate = 1'b1;
        wr_mode(3'd0, 1'b0);
        check("R4", "tmr_out", {15'b0, tmr_out}, 16'h0);
        wr_count(16'd5);
        w = cyc;
        check("R3", "null_count", {15'b0, null_count}, 16'h1);
        push(w + 1, 1, 16'h0, "R3");
        expect_out(w + 1, w + 5, 1'b0, "R4");
        expect_out(w + 6, w + 9, 1'b1, "R4");
        wait_until(w + 10);
        wr_mode(3'd0, 1'b0);
        check("R4", "tmr_out after mode write", {15'b0, tmr_out}, 16'h0);
        check("R3", "null_count after mode write", {15'b0, null_count}, 16'h1);

        // R5 gate pause and latch, mode 0, N=6
        wr_count(16'd6);
        w = cyc;
        expect_out(w + 1, w + 9, 1'b0, "R5");
        expect_out(w + 10, w + 11, 1'b1, "R5");
        push(w + 5, 2, 16'd4, "R5");
        push(w + 6, 2, 16'd4, "R5");
        wait_until(w + 3); gate = 1'b0;
        wait_until(w + 4); latch_req = 1'b1;
        wait_until(w + 5); latch_req = 1'b0;
        wait_until(w + 6); gate = 1'b1;
        wait_until(w + 12);

        // R11 decimal count 12 and digit borrow
        wr_mode(3'd0, 1'b1);
        wr_count(16'h0012);
        w = cyc;
        expect_out(w + 11, w + 12, 1'b0, "R11");
        push(w + 13, 0, 16'h1, "R11");
        push(w + 5, 2, 16'h0009, "R11");
        wait_until(w + 4); latch_req = 1'b1;
        wait_until(w + 5); latch_req = 1'b0;
        wait_until(w + 14);

        // R12 zero count, decimal then binary
        wr_mode(3'd0, 1'b1);
        wr_count(16'h0000);
        w = cyc;
        push(w + 10000, 0, 16'h0, "R12");
        push(w + 10001, 0, 16'h1, "R12");
        wait_until(w + 10002);
        wr_mode(3'd0, 1'b0);
        wr_count(16'h0000);
        w = cyc;
        push(w + 65536, 0, 16'h0, "R12");
        push(w + 65537, 0, 16'h1, "R12");
        wait_until(w + 65538);

        // R6 one-shot
        gate = 1'b0;
        wr_mode(3'd1, 1'b0);
        check("R6", "tmr_out after mode write", {15'b0, tmr_out}, 16'h1);
        wr_count(16'd3);
        w = cyc;
        expect_out(w + 1, w + 4, 1'b1, "R6");
        wait_until(w + 4);
        e = w + 5;
        expect_out(e, e + 2, 1'b0, "R6");
        expect_out(e + 3, e + 4, 1'b1, "R6");
        push(e, 1, 16'h0, "R3");
        gate = 1'b1;
        wait_until(e + 3); gate = 1'b0;
        wait_until(e + 5);
        wr_count(16'd2);
        check("R3", "null_count after rewrite", {15'b0, null_count}, 16'h1);
        f = cyc + 1;
        expect_out(f, f + 1, 1'b0, "R6");
        expect_out(f + 2, f + 3, 1'b1, "R6");
        gate = 1'b1;
        wait_until(f + 4); gate = 1'b0;
        wait_until(f + 5);
        g = f + 6;
        expect_out(g, g + 3, 1'b0, "R6");
        expect_out(g + 4, g + 5, 1'b1, "R6");
        gate = 1'b1;
        wait_until(g); gate = 1'b0;
        wait_until(g + 1); gate = 1'b1;
        wait_until(g + 6);

        // R7 rate generator N=4, then alias code 6 with N=3
        wr_mode(3'd2, 1'b0);
        check("R7", "tmr_out after mode write", {15'b0, tmr_out}, 16'h1);
        wr_count(16'd4);
        w = cyc;
        for (int k = 1; k <= 13; k++) push(w + k, 0, (k % 4 == 0) ? 16'h0 : 16'h1, "R7");
        wait_until(w + 14);
        wr_mode(3'd6, 1'b0);
        wr_count(16'd3);
        w = cyc;
        for (int k = 1; k <= 10; k++) push(w + k, 0, (k % 3 == 0) ? 16'h0 : 16'h1, "R2");
        wait_until(w + 11);

        // R8 square wave N=6, then alias code 7 with odd N=5
        wr_mode(3'd3, 1'b0);
        check("R8", "tmr_out after mode write", {15'b0, tmr_out}, 16'h1);
        wr_count(16'd6);
        w = cyc;
        for (int k = 1; k <= 12; k++) push(w + k, 0, ((k - 1) % 6 < 3) ? 16'h1 : 16'h0, "R8");
        wait_until(w + 13);
        wr_mode(3'd7, 1'b0);
        wr_count(16'd5);
        w = cyc;
        for (int k = 1; k <= 10; k++) push(w + k, 0, ((k - 1) % 5 < 3) ? 16'h1 : 16'h0, "R8 R2");
        wait_until(w + 11);

        // R9 software strobe N=3
        wr_mode(3'd4, 1'b0);
        wr_count(16'd3);
        w = cyc;
        expect_out(w + 1, w + 3, 1'b1, "R9");
        push(w + 4, 0, 16'h0, "R9");
        expect_out(w + 5, w + 12, 1'b1, "R9");
        wait_until(w + 13);

        // R10 hardware strobe N=2
        gate = 1'b0;
        wr_mode(3'd5, 1'b0);
        wr_count(16'd2);
        w = cyc;
        expect_out(w + 1, w + 5, 1'b1, "R10");
        wait_until(w + 5);
        check("R3", "null_count before trigger", {15'b0, null_count}, 16'h1);
        e = w + 6;
        expect_out(e, e + 1, 1'b1, "R10");
        push(e + 2, 0, 16'h0, "R10");
        expect_out(e + 3, e + 6, 1'b1, "R10");
        push(e, 1, 16'h0, "R3");
        gate = 1'b1;
        wait_until(e + 3); gate = 1'b0;
        wait_until(e + 4);
        h = e + 5;
        push(h + 2, 0, 16'h0, "R10");
        expect_out(h + 3, h + 4, 1'b1, "R10");
        gate = 1'b1;
        wait_until(h + 5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule